// File: doc/BRIEF.md
# VCO Coarse-Tune Successive-Approximation Calibrator

This block picks the 8-bit capacitor-bank code of a VCO by successive approximation. Software starts a run by writing 1 to a self-clearing start bit. The block then opens the PLL feedback loop and settles the code one bit at a time, from the most significant bit down to the least significant. For each bit it sets a trial 1, waits a programmable settling interval and samples a frequency comparator. When every bit is resolved it closes the loop again, clears the start bit and pulses a completion flag. The resulting code stays on the output until the next run.

The comparator flag `freq_low` is high when the VCO runs below its target frequency. A trial bit stays set when that flag is high at the end of its interval, and is cleared otherwise. The interval for each bit is 2^(res_sel+4) clock cycles. The resolution setting is captured when a run starts.

States: `ST_IDLE` (waiting, loop closed), `ST_OPEN` (one cycle: loop opened, code cleared), `ST_SETTLE` (trial bit applied, timer running), `ST_DECIDE` (one cycle: comparator sampled, bit resolved, next trial bit set) and `ST_FINISH` (one cycle: loop restored, start bit cleared, done pulse). Transitions: IDLE→OPEN on a start write. OPEN→SETTLE always. SETTLE→DECIDE when the timer expires. DECIDE→SETTLE while bits remain. DECIDE→FINISH after the last bit. FINISH→OPEN on a start write, otherwise FINISH→IDLE.

Top module: `vco_sar_cal`

## Requirements
- R1: While reset is asserted and right after it is released, `code` is 0 and `busy`, `loop_open` and `done` are all low.
- R2: A start write seen at a clock edge while idle raises `busy` in the next cycle. `busy` is the start bit and stays high until the search completes.
- R3: `loop_open` is high exactly while `busy` is high, so the loop stays open for the whole run and is closed again in the done cycle.
- R4: In the first busy cycle `code` is 0. After that, bit positions 7 down to 0 are tried in turn. The trial code for bit b holds the bits already resolved above b, a 1 at b and zeros below b.
- R5: Each trial code is held for 2^(res_sel+4)+1 cycles. This is the settling interval plus one decision cycle. A run therefore keeps `busy` high for 1+8·(2^(res_sel+4)+1) cycles.
- R6: A trial bit stays 1 when `freq_low` is 1 in its decision cycle and becomes 0 otherwise. With a monotone comparator, the final code is the largest code for which `freq_low` is 1.
- R7: Completion gives a single-cycle `done` pulse in the cycle where `busy` falls. `code` already shows the final result in that cycle.
- R8: A start write while `busy` is high is ignored and does not change the timing or the result of the run.
- R9: `res_sel` is sampled only at the start write. Changing it during a run has no effect on that run.
- R10: A start write in the `done` cycle starts a new run, with `busy` high in the next cycle.
- R11: While not busy and with no start write, `code` holds its value. A start write clears it to 0 in the first busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_wr | input | 1 | One-cycle software write of 1 to the start bit |
| freq_low | input | 1 | Comparator: 1 = VCO below target frequency |
| res_sel | input | 2 | Settling resolution; interval is 2^(res_sel+4) cycles |
| code | output | 8 | Capacitor-bank code (trial during a run, result after) |
| loop_open | output | 1 | 1 = PLL feedback loop broken |
| busy | output | 1 | Start bit readback; high while calibrating |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The comparator is modelled as "code ≤ target", and the search is run with the targets 0x00, 0xFF, 0xA5, 0x37 and 0x5A. The two extremes show whether the all-clear and all-keep decision paths work. The alternating patterns show whether each bit is decided from its own sample and in MSB-first order. Each resolution setting is used once, so an error in the settling length shows up as a shifted trial timeline. Other runs add a stray start write and a change of `res_sel` in mid-run, a restart in the done cycle and a long idle stretch. These separate the ignore, capture, restart and hold behaviour from the normal sequence.

// File: rtl/vco_sar_pkg.sv
package vco_sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPEN   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_DECIDE = 3'd3,
        ST_FINISH = 3'd4
    } cal_state_e;

endpackage

// File: rtl/vco_sar_timer.sv
module vco_sar_timer #(
    parameter int RES_W     = 2,
    parameter int WAIT_BASE = 4,
    localparam int CNT_W    = WAIT_BASE + (1 << RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] res,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = (CNT_W'(1) << (int'(res) + WAIT_BASE)) - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (cnt_q != last_cnt) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expire = (cnt_q == last_cnt);

endmodule

// File: rtl/vco_sar_code.sv
module vco_sar_code #(
    parameter int CODE_W   = 8,
    localparam int IDX_W   = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              res_en,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic              res_val,
    input  logic              trial_en,
    input  logic [IDX_W-1:0]  trial_idx,
    output logic [CODE_W-1:0] code
);

    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code[i] <= 1'b0;
            end else if (clr) begin
                code[i] <= 1'b0;
            end else if (res_en && (res_idx == IDX_W'(i))) begin
                code[i] <= res_val;
            end else if (trial_en && (trial_idx == IDX_W'(i))) begin
                code[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vco_sar_cal.sv
module vco_sar_cal
    import vco_sar_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int RES_W     = 2,
    parameter int WAIT_BASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              freq_low,
    input  logic [RES_W-1:0]  res_sel,
    output logic [CODE_W-1:0] code,
    output logic              loop_open,
    output logic              busy,
    output logic              done
);

    localparam int IDX_W = $clog2(CODE_W);
    localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(CODE_W - 1);

    cal_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [RES_W-1:0] res_q;
    logic             accept;
    logic             tmr_load, tmr_expire;
    logic             code_clr, res_en, trial_en;
    logic [IDX_W-1:0] trial_idx;

    assign accept = start_wr && ((state_q == ST_IDLE) || (state_q == ST_FINISH));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (accept) begin
                res_q <= res_sel;
            end
        end
    end

    // Next-state and datapath controls
    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        tmr_load  = 1'b0;
        code_clr  = 1'b0;
        res_en    = 1'b0;
        trial_en  = 1'b0;
        trial_idx = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr) begin
                    state_d  = ST_OPEN;
                    code_clr = 1'b1;
                end
            end
            ST_OPEN: begin
                state_d   = ST_SETTLE;
                idx_d     = MSB_IDX;
                trial_en  = 1'b1;
                trial_idx = MSB_IDX;
                tmr_load  = 1'b1;
            end
            ST_SETTLE: begin
                if (tmr_expire) begin
                    state_d = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                res_en = 1'b1;
                if (idx_q == '0) begin
                    state_d = ST_FINISH;
                end else begin
                    state_d   = ST_SETTLE;
                    idx_d     = idx_q - IDX_W'(1);
                    trial_en  = 1'b1;
                    trial_idx = idx_q - IDX_W'(1);
                    tmr_load  = 1'b1;
                end
            end
            ST_FINISH: begin
                if (start_wr) begin
                    state_d  = ST_OPEN;
                    code_clr = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        loop_open = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_OPEN, ST_SETTLE, ST_DECIDE: begin
                busy      = 1'b1;
                loop_open = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    vco_sar_timer #(
        .RES_W    (RES_W),
        .WAIT_BASE(WAIT_BASE)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .res   (res_q),
        .expire(tmr_expire)
    );

    vco_sar_code #(
        .CODE_W(CODE_W)
    ) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (code_clr),
        .res_en   (res_en),
        .res_idx  (idx_q),
        .res_val  (freq_low),
        .trial_en (trial_en),
        .trial_idx(trial_idx),
        .code     (code)
    );

endmodule

// File: rtl/vco_sar_cal_chk.sv
module vco_sar_cal_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_wr,
    input logic [CODE_W-1:0] code,
    input logic              loop_open,
    input logic              busy,
    input logic              done
);

    a_r2_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_wr));

    a_r3_loop_closed_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loop_open) |-> done);

    a_r4_first_trial_msb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (code == {1'b1, {(CODE_W-1){1'b0}}}));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_busy_end_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r11_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_wr) |=> $stable(code));

endmodule

bind vco_sar_cal vco_sar_cal_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (start_wr),
    .code     (code),
    .loop_open(loop_open),
    .busy     (busy),
    .done     (done)
);

// File: tb/vco_sar_cal_tb.sv
module vco_sar_cal_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_wr = 1'b0;
    logic       freq_low;
    logic [1:0] res_sel = 2'd0;
    logic [7:0] code;
    logic       loop_open, busy, done;
    logic [7:0] tgt = 8'h00;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    assign freq_low = (code <= tgt);

    vco_sar_cal u_dut (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .freq_low(freq_low),
        .res_sel(res_sel), .code(code), .loop_open(loop_open), .busy(busy), .done(done)
    );

    // Behavioural reference: timeline position since an accepted start
    bit       m_act = 1'b0;
    int       m_t = 0;
    int       m_w = 16;
    int       m_tgt = 0;
    int       m_last = 0;

    function automatic int t_done(int w);
        return 2 + 8 * (w + 1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act <= 1'b0; m_t <= 0; m_last <= 0;
        end else if (start_wr && (!m_act || m_t == t_done(m_w))) begin
            m_act <= 1'b1; m_t <= 1; m_w <= 16 << res_sel; m_tgt <= int'(tgt);
        end else if (m_act) begin
            if (m_t == t_done(m_w)) begin
                m_act <= 1'b0; m_last <= m_tgt;
            end else begin
                m_t <= m_t + 1;
            end
        end
    end

    function automatic int exp_code();
        int s, b;
        if (!m_act) return m_last;
        if (m_t == 1) return 0;
        if (m_t == t_done(m_w)) return m_tgt;
        s = (m_t - 2) / (m_w + 1);
        b = 7 - s;
        return (m_tgt & ~((1 << (b + 1)) - 1) & 255) | (1 << b);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            bit eb;
            eb = m_act && m_t < t_done(m_w);
            chk({phase, " R2 busy"}, int'(busy), int'(eb));
            chk({phase, " R3 loop_open"}, int'(loop_open), int'(eb));
            chk({phase, " R7 done"}, int'(done), int'(m_act && m_t == t_done(m_w)));
            chk({phase, " R4 code"}, int'(code), exp_code());
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_wr = 1'b1;
        @(negedge clk) start_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_act) @(negedge clk);
    endtask

    task automatic run_cal(int res, logic [7:0] t, string tag);
        phase = tag; tgt = t; res_sel = 2'(res);
        pulse_start();
        wait_idle();
        @(negedge clk);
        chk({tag, " R6 result"}, int'(code), int'(t));
    endtask

    task automatic tests();
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1 reset code", int'(code), 0);
            chk("R1 reset flags", int'({busy, loop_open, done}), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'({code, busy, loop_open, done}), 0);
        cmp_on = 1'b1;

        run_cal(0, 8'hA5, "R5 R6 res0");
        run_cal(1, 8'h00, "R5 R6 res1");
        run_cal(2, 8'hFF, "R5 R6 res2");

        // R8, R9: stray start and res_sel change during a res3 run
        phase = "R8 R9"; tgt = 8'h37; res_sel = 2'd3;
        pulse_start();
        repeat (50) @(negedge clk);
        res_sel = 2'd0;
        pulse_start();
        repeat (300) @(negedge clk);
        pulse_start();
        wait_idle();
        @(negedge clk);
        chk("R8 R9 result", int'(code), 8'h37);

        // R10: restart in the done cycle
        phase = "R10"; tgt = 8'h5A; res_sel = 2'd0;
        pulse_start();
        while (!done) @(negedge clk);
        start_wr = 1'b1;
        @(negedge clk) start_wr = 1'b0;
        chk("R10 restart busy", int'(busy), 1);
        chk("R10 restart code cleared", int'(code), 0);
        wait_idle();
        @(negedge clk);
        chk("R10 result", int'(code), 8'h5A);

        // R11: hold while idle
        phase = "R11";
        tgt = 8'h00;
        repeat (40) @(negedge clk);
        chk("R11 held code", int'(code), 8'h5A);
    endtask

    initial begin
        fork
            tests();
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule